// File: doc/BRIEF.md
# Burst-Clocked SAR Converter Readout Controller

This block runs an external successive-approximation converter from the host side of the link. At the start of every sample period it raises a conversion-start strobe. It then waits a programmed number of system-clock cycles for the result to settle, and after that it drives a gated serial clock for exactly one 18-bit word. The serial clock stays low at all other times. Serial data arrive most significant bit first. The controller captures them either on its own burst clock (host-clocked mode) or on a copy of that clock that the converter sends back (echoed mode). The finished word is presented with a one-cycle valid pulse, and it always belongs to the strobe that started the same period.

All timing is counted in system-clock cycles and comes from run-time configuration inputs: the sample period, the conversion wait and the strobe width. At a 250 MHz system clock, full converter throughput (5 million conversions per second) is a period of 50 cycles. If a period is too short for the conversion wait plus the burst, the controller never cuts a read short. It sets a sticky overrun flag and drops the strobe that would have collided. In echoed mode, a sticky timeout flag reports that fewer than 18 echoed rising edges arrived within a bounded window after the last burst pulse.

The controller is a five-state machine: IDLE, CONVERT, BURST, ECHO_WAIT and DONE. The transitions are:
- IDLE→CONVERT on a period tick.
- CONVERT→BURST when the conversion wait has elapsed.
- BURST→DONE on the last pulse in host-clocked mode.
- BURST→ECHO_WAIT on the last pulse in echoed mode.
- ECHO_WAIT→DONE once 18 echoed bits have been captured.
- ECHO_WAIT→IDLE when the echo window expires.
- DONE→IDLE unconditionally.

Top module: `sar_burst_reader`

## Requirements
- R1: After reset, `cnv_out`, `sclk_out`, `word_valid`, `overrun_flag` and `echo_timeout` are all 0.
- R2: While `enable` is 1, a period tick occurs every `cfg_period` cycles, and the first tick falls in the first enabled cycle. A tick in IDLE raises `cnv_out` for min(`cfg_strobe_width`, `cfg_conv_wait`) cycles, starting in the cycle after the tick. No strobe is ever raised while `enable` is 0.
- R3: The first rising edge of `sclk_out` comes `cfg_conv_wait`+1 cycles after `cnv_out` rises. A burst has exactly 18 pulses, each high for one cycle and low for one cycle. `sclk_out` is 0 outside the burst, including whenever `cnv_out` is 1.
- R4: With `cfg_echo_mode`=0, `sdata_in` is sampled at the end of each cycle in which `sclk_out` is high. The first sample becomes `word_data[17]` and the last becomes `word_data[0]`.
- R5: With `cfg_echo_mode`=1, `sdata_in` and `echo_clk_in` pass through matching two-stage synchronizers. A bit is taken on each synchronized rising edge of `echo_clk_in`, MSB first, and at most 18 bits are taken per burst.
- R6: `word_valid` is high for exactly one cycle per completed word. `word_data` then equals the full 18-bit result of the most recent strobe, with no pipeline delay.
- R7: A period tick that arrives outside IDLE sets `overrun_flag`, which stays set until reset. That strobe is skipped, and the read in progress completes unchanged. In host-clocked mode the minimum period without overrun is `cfg_conv_wait`+38.
- R8: In echoed mode, if 18 echoed bits have not been captured within `ECHO_WIN` cycles after the burst ends, `echo_timeout` is set and stays set until reset. That read then produces no `word_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Allows period ticks; low holds the period counter at zero |
| cfg_period | input | CNT_W | Sample period in system cycles |
| cfg_conv_wait | input | CNT_W | Cycles from strobe start until the burst may begin |
| cfg_strobe_width | input | PW_W | Conversion-start pulse width in cycles |
| cfg_echo_mode | input | 1 | 0: capture on own burst clock, 1: capture on echoed clock |
| sdata_in | input | 1 | Serial result from the converter |
| echo_clk_in | input | 1 | Clock echoed back by the converter |
| cnv_out | output | 1 | Conversion-start strobe |
| sclk_out | output | 1 | Burst serial clock, idle low |
| word_valid | output | 1 | One-cycle pulse marking a complete word |
| word_data | output | WORD_W | Assembled result, MSB first on the line |
| overrun_flag | output | 1 | Sticky: period too short, a strobe was skipped |
| echo_timeout | output | 1 | Sticky: echoed edges missing after a burst |

## Verification
A wrong bit index or phase register shows up in the same period. The burst then carries a pulse count other than 18, or the word comes out rotated, before `word_valid` of that read. A conversion counter that is off by one moves the first serial-clock rise away from `cfg_conv_wait`+1 cycles after the strobe, which is visible on the very first read. A state machine that leaves IDLE late, or stays out of it, shows at the next period tick as a missing strobe and a raised `overrun_flag`. A broken echo capture path shows either as a wrong word or as `echo_timeout` within `ECHO_WIN` cycles of the burst's end.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int SBR_WORD_W = 18;

    typedef enum logic [2:0] {
        S_IDLE      = 3'd0,
        S_CONV      = 3'd1,
        S_BURST     = 3'd2,
        S_ECHO_WAIT = 3'd3,
        S_DONE      = 3'd4
    } sbr_state_e;

endpackage

// File: rtl/sbr_period_timer.sv
module sbr_period_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + (CNT_W+1)'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!enable) begin
            cnt_q <= '0;
        end else if (cnt_inc >= {1'b0, period}) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    assign tick = enable && (cnt_q == '0);

endmodule

// File: rtl/sbr_capture.sv
module sbr_capture #(
    parameter int WORD_W = 18,
    parameter int BIT_W  = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              echo_mode,
    input  logic              own_shift,
    input  logic              sdata_i,
    input  logic              echo_i,
    output logic [WORD_W-1:0] word_o,
    output logic [BIT_W-1:0]  bits_o
);

    logic e_s1, e_s2, e_s3;
    logic d_s1, d_s2;
    logic echo_rise;
    logic take;
    logic bit_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_s1 <= 1'b0;
            e_s2 <= 1'b0;
            e_s3 <= 1'b0;
            d_s1 <= 1'b0;
            d_s2 <= 1'b0;
        end else begin
            e_s1 <= echo_i;
            e_s2 <= e_s1;
            e_s3 <= e_s2;
            d_s1 <= sdata_i;
            d_s2 <= d_s1;
        end
    end

    assign echo_rise = e_s2 && !e_s3;
    assign bit_in    = echo_mode ? d_s2 : sdata_i;
    assign take      = (bits_o < BIT_W'(WORD_W)) &&
                       (echo_mode ? echo_rise : own_shift);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_o <= '0;
            bits_o <= '0;
        end else if (clear) begin
            word_o <= '0;
            bits_o <= '0;
        end else if (take) begin
            word_o <= {word_o[WORD_W-2:0], bit_in};
            bits_o <= bits_o + BIT_W'(1);
        end
    end

    // R5: the count only moves on an accepted bit and never runs past a word
    p_bits_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && bits_o == BIT_W'(WORD_W)) |=> (bits_o == BIT_W'(WORD_W) || $past(clear)));

endmodule

// File: rtl/sar_burst_reader.sv
module sar_burst_reader
    import sbr_pkg::*;
#(
    parameter int WORD_W   = SBR_WORD_W,
    parameter int CNT_W    = 16,
    parameter int PW_W     = 8,
    parameter int ECHO_WIN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [CNT_W-1:0]  cfg_period,
    input  logic [CNT_W-1:0]  cfg_conv_wait,
    input  logic [PW_W-1:0]   cfg_strobe_width,
    input  logic              cfg_echo_mode,
    input  logic              sdata_in,
    input  logic              echo_clk_in,
    output logic              cnv_out,
    output logic              sclk_out,
    output logic              word_valid,
    output logic [WORD_W-1:0] word_data,
    output logic              overrun_flag,
    output logic              echo_timeout
);

    localparam int BIT_W = $clog2(WORD_W + 1);
    localparam int WIN_W = $clog2(ECHO_WIN + 1);

    sbr_state_e        state_q, state_d;
    logic              tick;
    logic              start;
    logic [CNT_W-1:0]  conv_cnt_q;
    logic [BIT_W-1:0]  bit_idx_q;
    logic              phase_q;
    logic [WIN_W-1:0]  win_cnt_q;
    logic              mode_q;
    logic              overrun_q;
    logic              timeout_q;
    logic [WORD_W-1:0] cap_word;
    logic [BIT_W-1:0]  cap_bits;
    logic              conv_done;
    logic              last_bit;
    logic              win_expired;
    logic              cap_full;
    logic              own_shift;

    sbr_period_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (enable),
        .period (cfg_period),
        .tick   (tick)
    );

    assign start       = tick && (state_q == S_IDLE);
    assign conv_done   = ({1'b0, conv_cnt_q} + (CNT_W+1)'(1)) >= {1'b0, cfg_conv_wait};
    assign last_bit    = phase_q && (bit_idx_q == BIT_W'(WORD_W - 1));
    assign win_expired = (win_cnt_q == WIN_W'(ECHO_WIN - 1));
    assign cap_full    = (cap_bits == BIT_W'(WORD_W));
    assign own_shift   = (state_q == S_BURST) && phase_q;

    sbr_capture #(.WORD_W(WORD_W), .BIT_W(BIT_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .echo_mode (mode_q),
        .own_shift (own_shift),
        .sdata_i   (sdata_in),
        .echo_i    (echo_clk_in),
        .word_o    (cap_word),
        .bits_o    (cap_bits)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_CONV;
            S_CONV:      if (conv_done) state_d = S_BURST;
            S_BURST:     if (last_bit) state_d = mode_q ? S_ECHO_WAIT : S_DONE;
            S_ECHO_WAIT: begin
                if (cap_full)         state_d = S_DONE;
                else if (win_expired) state_d = S_IDLE;
            end
            S_DONE:      state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // counters and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            conv_cnt_q <= '0;
            bit_idx_q  <= '0;
            phase_q    <= 1'b0;
            win_cnt_q  <= '0;
            mode_q     <= 1'b0;
            overrun_q  <= 1'b0;
            timeout_q  <= 1'b0;
        end else begin
            conv_cnt_q <= (state_q == S_CONV) ? conv_cnt_q + CNT_W'(1) : '0;
            if (state_q == S_BURST) begin
                phase_q <= !phase_q;
                if (phase_q) bit_idx_q <= bit_idx_q + BIT_W'(1);
            end else begin
                phase_q   <= 1'b0;
                bit_idx_q <= '0;
            end
            win_cnt_q <= (state_q == S_ECHO_WAIT) ? win_cnt_q + WIN_W'(1) : '0;
            if (start) mode_q <= cfg_echo_mode;
            if (tick && state_q != S_IDLE) overrun_q <= 1'b1;
            if (state_q == S_ECHO_WAIT && !cap_full && win_expired) timeout_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        cnv_out      = (state_q == S_CONV) && (conv_cnt_q < CNT_W'(cfg_strobe_width));
        sclk_out     = (state_q == S_BURST) && phase_q;
        word_valid   = (state_q == S_DONE);
        word_data    = cap_word;
        overrun_flag = overrun_q;
        echo_timeout = timeout_q;
    end

    // R3: serial clock is quiet while the strobe is up
    p_quiet_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_out |-> !sclk_out);

    // R3: every pulse lasts a single cycle
    p_clock_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_out |=> !sclk_out);

    // R4: in host-clocked mode the captured count tracks the pulse index
    p_own_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_shift && !mode_q) |-> (cap_bits == bit_idx_q));

    // R6: valid is a single-cycle pulse
    p_valid_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R6: a valid word is always complete
    p_valid_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> cap_full);

    // R7: overrun is sticky
    p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_flag |=> overrun_flag);

    // R8: timeout is sticky
    p_timeout_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        echo_timeout |=> echo_timeout);

endmodule

// File: tb/sar_burst_reader_tb.sv
`timescale 1ns/1ps
module sar_burst_reader_tb;

    localparam real CLK_NS = 4.0;
    localparam int  WD_CYC = 150000;
    localparam int  LAG    = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [15:0] cfg_period = 16'd50;
    logic [15:0] cfg_conv_wait = 16'd8;
    logic [7:0]  cfg_strobe_width = 8'd2;
    logic        cfg_echo_mode = 1'b0;
    logic        sdata_in = 1'b0;
    logic        echo_clk_in = 1'b0;
    logic        cnv_out, sclk_out, word_valid, overrun_flag, echo_timeout;
    logic [17:0] word_data;

    int checks = 0;
    int fails = 0;
    int valids = 0;
    int strobes = 0;
    bit finished = 0;

    // converter model state
    logic [17:0] cur_sample = '0;
    int          bit_pos = 0;
    int          since_cnv = 0;
    int          cnv_len = 0;
    int          last_w = 0;
    int          last_gap = 0;
    int          rises = 0;
    int          first_delay = -1;
    int          echo_limit = 99;
    logic        mask_hi = 1'b0;
    logic [LAG-1:0] pipe = '0;
    logic        p_cnv = 1'b0, p_sclk = 1'b0, p_echo = 1'b0;

    sar_burst_reader u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_period(cfg_period), .cfg_conv_wait(cfg_conv_wait),
        .cfg_strobe_width(cfg_strobe_width), .cfg_echo_mode(cfg_echo_mode),
        .sdata_in(sdata_in), .echo_clk_in(echo_clk_in),
        .cnv_out(cnv_out), .sclk_out(sclk_out), .word_valid(word_valid),
        .word_data(word_data), .overrun_flag(overrun_flag), .echo_timeout(echo_timeout)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_width(input int sw, input int w);
        return (sw < w) ? sw : w;
    endfunction

    // converter model and monitor, all on the falling edge
    always @(negedge clk) begin
        logic e_new;
        since_cnv++;
        if (cnv_out && !p_cnv) begin
            last_gap    = since_cnv;
            since_cnv   = 0;
            cnv_len     = 0;
            rises       = 0;
            first_delay = -1;
            cur_sample  = 18'($urandom);
            bit_pos     = 17;
            sdata_in    = cur_sample[17];
            strobes++;
        end
        if (cnv_out) cnv_len++;
        if (!cnv_out && p_cnv) last_w = cnv_len;
        if (sclk_out && !p_sclk) begin
            if (rises == 0) first_delay = since_cnv;
            mask_hi = (rises < echo_limit);
            rises++;
        end
        pipe        = {pipe[LAG-2:0], sclk_out & mask_hi};
        e_new       = pipe[LAG-1];
        echo_clk_in = e_new;
        if (!cfg_echo_mode && p_sclk && !sclk_out) bit_pos--;
        if (cfg_echo_mode && p_echo && !e_new) bit_pos--;
        if (bit_pos >= 0) sdata_in = cur_sample[bit_pos];
        if (word_valid) begin
            int ew;
            ew = exp_width(int'(cfg_strobe_width), int'(cfg_conv_wait));
            chk(word_data == cur_sample, cfg_echo_mode ? "R5/R6 word" : "R4/R6 word",
                int'(word_data), int'(cur_sample));
            chk(rises == 18, "R3 pulse count", rises, 18);
            chk(first_delay == int'(cfg_conv_wait) + 1, "R3 burst start", first_delay,
                int'(cfg_conv_wait) + 1);
            chk(last_w == ew, "R2 strobe width", last_w, ew);
            valids++;
        end
        p_cnv  = cnv_out;
        p_sclk = sclk_out;
        p_echo = e_new;
    end

    task automatic do_reset();
        enable = 1'b0;
        rst_n  = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_valids(input int n);
        int target;
        target = valids + n;
        while (valids < target) @(posedge clk);
    endtask

    task automatic run_cfg(input bit mode, input int w, input int sw, input int p, input int n);
        @(negedge clk);
        cfg_echo_mode    = mode;
        cfg_conv_wait    = 16'(w);
        cfg_strobe_width = 8'(sw);
        cfg_period       = 16'(p);
        enable           = 1'b1;
        wait_valids(n);
        @(negedge clk);
        enable = 1'b0;
        repeat (150) @(posedge clk);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    initial begin
        #(WD_CYC * CLK_NS);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end

    initial begin
        int s0;
        int v0;
        void'($urandom(32'h5A17));
        do_reset();
        @(negedge clk);
        // R1 reset state
        chk(cnv_out == 0, "R1 cnv", cnv_out, 0);
        chk(sclk_out == 0, "R1 sclk", sclk_out, 0);
        chk(word_valid == 0, "R1 valid", word_valid, 0);
        chk(overrun_flag == 0 && echo_timeout == 0, "R1 flags",
            int'({overrun_flag, echo_timeout}), 0);

        // directed corners: shortest wait, strobe longer than wait
        run_cfg(1'b0, 1, 1, 40, 3);
        run_cfg(1'b0, 5, 8, 43, 3);
        run_cfg(1'b1, 4, 2, 70, 3);
        // random configurations with safe periods
        for (int i = 0; i < 8; i++) begin
            bit m;
            int w, sw, p;
            m  = 1'($urandom % 2);
            w  = 2 + int'($urandom % 14);
            sw = 1 + int'($urandom % w);
            p  = m ? w + 60 + int'($urandom % 8) : w + 38 + int'($urandom % 8);
            run_cfg(m, w, sw, p, 4);
        end
        chk(overrun_flag == 0, "R7 no overrun at safe period", overrun_flag, 0);
        chk(echo_timeout == 0, "R8 no timeout with full echo", echo_timeout, 0);

        // R2: no strobe while disabled
        s0 = strobes;
        repeat (300) @(posedge clk);
        chk(strobes == s0, "R2 disabled strobes", strobes, s0);

        // R7: one cycle too short -> overrun, every other strobe skipped
        run_cfg(1'b0, 6, 3, 43, 5);
        chk(overrun_flag == 1, "R7 overrun set", overrun_flag, 1);
        chk(last_gap == 86, "R7 strobe skipped", last_gap, 86);

        // R8: partial echo -> timeout, no valid
        do_reset();
        echo_limit = 10;
        v0 = valids;
        @(negedge clk);
        cfg_echo_mode = 1'b1;
        cfg_conv_wait = 16'd6;
        cfg_strobe_width = 8'd2;
        cfg_period = 16'd200;
        enable = 1'b1;
        repeat (120) @(posedge clk);
        @(negedge clk);
        enable = 1'b0;
        repeat (100) @(posedge clk);
        chk(echo_timeout == 1, "R8 timeout set", echo_timeout, 1);
        chk(valids == v0, "R8 no valid", valids, v0);
        chk(overrun_flag == 0, "R7 clear after reset", overrun_flag, 0);
        echo_limit = 99;

        finished = 1;
        summary();
        $finish;
    end

endmodule